// File: doc/BRIEF.md
# Per-Processor Limit / Free-Run Counter-Timer

This block is a memory-mapped counter-timer for one processor. It has two personalities, chosen by the level of an external mode input. In limit mode it counts ticks up to a programmable limit. When the limit is reached it sets a reached flag, raises its interrupt and starts again from zero. In free-run mode it is a wide counter that software can start and stop, and it never interrupts.

The counter advances once for every cycle in which the tick enable is high; the tick source, nominally one pulse every 500 ns, sits outside the block. Count and limit values are kept in a scaled form whose lowest nine bits always read as zero, so one tick adds 0x200 to the visible count.

Software reaches the block through a word-addressed port with a read strobe and a write strobe. Read data is registered and appears one cycle after the strobe. Changing personality takes a level on the mode input plus a one-cycle pulse on the mode-change input. The pulse brings the counter back to a known starting state.

Top module: `proc_ctimer`

## Requirements
- R1: After reset the interrupt is low, the count is zero, the reached flag is clear, the counter is running (word 3 reads 1), and in limit mode word 0 reads 0x7FFFFE00.
- R2: In limit mode a write to word 0 sets the limit to the written value ANDed with 0x7FFFFE00, or to 0x7FFFFE00 when that result is zero. It also zeroes the count and lowers the interrupt, and it leaves the reached flag as it was.
- R3: In limit mode a write to word 2 sets the limit with the same mask and zero substitution as R2 and leaves the count untouched.
- R4: In limit mode a read of word 0 returns the limit in bits [30:9], with all other bits zero. The same read clears the reached flag and lowers the interrupt; a limit hit in that same cycle wins.
- R5: In limit mode a read of word 1 returns count bits [30:9] in place and the reached flag in bit 31. This read has no side effect.
- R6: In limit mode, consider a tick that would bring the scaled count (count divided by 0x200) to or past the scaled limit. On that tick the count becomes zero, the reached flag sets and the interrupt rises. Without a tick the count holds.
- R7: In free-run mode the count is a 63-bit value whose bits [8:0] are zero. Word 0 returns bits [62:32] with bit 31 zero, and word 1 returns bits [31:0].
- R8: In free-run mode a write to word 0 or to word 1 zeroes the count. In limit mode a write to word 1 has no effect.
- R9: In free-run mode, writing word 3 with bit 0 set starts the counter and writing it with bit 0 clear stops it; a stopped counter holds its value through ticks. Word 3 reads the run status in bit 0. In limit mode a write to word 3 is ignored and the counter keeps counting.
- R10: The interrupt never rises while the mode input selects free-run mode.
- R11: Words 4 to 7 read as zero, and writes to them change nothing.
- R12: A one-cycle pulse on the mode-change input zeroes the count, clears the reached flag, lowers the interrupt, restores the limit to 0x7FFFFE00 and leaves the counter running.
- R13: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per counting step |
| user_mode_i | input | 1 | 1 selects free-run mode, 0 selects limit mode |
| mode_chg_i | input | 1 | One-cycle pulse that restarts the counter after a mode change |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, level, limit mode only |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, 9 scaling bits, a 22-bit limit field and a 54-bit count field. Because a limit as small as 0x600 can be written, a few ticks are enough to reach the wrap, the reached flag and the interrupt, including the case where a limit lowered by word 2 meets a count already in progress. Free-run counting, start/stop and the count-zeroing writes are checked only in the lower word. Carrying into word 0 would take millions of ticks, so that word is checked only for reading zero.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

    localparam int unsigned TMR_AW = 3;

    typedef enum logic [TMR_AW-1:0] {
        WD_LIM  = 3'd0,
        WD_CNT  = 3'd1,
        WD_LIMK = 3'd2,
        WD_RUN  = 3'd3
    } word_e;

    typedef struct packed {
        logic ld_lim;
        logic cnt_clr;
        logic irq_clr;
        logic rd_clr;
        logic run_wr;
    } tmr_ctl_t;

endpackage

// File: rtl/ctimer_decode.sv
module ctimer_decode
    import ctimer_pkg::*;
(
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              user_i,
    input  logic [TMR_AW-1:0] addr_i,
    output tmr_ctl_t          ctl_o
);

    logic is_lim, is_cnt, is_limk, is_run;

    always_comb begin
        is_lim  = 1'b0;
        is_cnt  = 1'b0;
        is_limk = 1'b0;
        is_run  = 1'b0;
        case (addr_i)
            WD_LIM:  is_lim  = 1'b1;
            WD_CNT:  is_cnt  = 1'b1;
            WD_LIMK: is_limk = 1'b1;
            WD_RUN:  is_run  = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        ctl_o         = '0;
        ctl_o.ld_lim  = wr_en_i && !user_i && (is_lim || is_limk);
        ctl_o.cnt_clr = wr_en_i && (is_lim || (user_i && is_cnt));
        ctl_o.rd_clr  = rd_en_i && !user_i && is_lim;
        ctl_o.irq_clr = ctl_o.cnt_clr || ctl_o.rd_clr;
        ctl_o.run_wr  = wr_en_i && user_i && is_run;
    end

endmodule

// File: rtl/ctimer_count.sv
module ctimer_count #(
    parameter int unsigned FIELD_W = 54
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic               wrap_en_i,
    input  logic [FIELD_W-1:0] lim_i,
    output logic [FIELD_W-1:0] cnt_o,
    output logic               hit_o
);

    typedef struct packed {
        logic [FIELD_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t        st_d, st_q;
    logic [FIELD_W:0] inc;

    always_comb begin
        st_d  = st_q;
        inc   = {1'b0, st_q.cnt} + {{FIELD_W{1'b0}}, 1'b1};
        hit_o = adv_i && wrap_en_i && !clr_i && (inc >= {1'b0, lim_i});
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (adv_i) begin
            st_d.cnt = hit_o ? '0 : inc[FIELD_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |=> (cnt_o == '0)) else $error("wrap did not zero count"); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !clr_i) |=> $stable(cnt_o)) else $error("count moved without tick"); // R9

endmodule

// File: rtl/ctimer_rdmux.sv
module ctimer_rdmux
    import ctimer_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FRAC_W  = 9,
    parameter int unsigned LIMF_W  = 22,
    parameter int unsigned FIELD_W = 54
) (
    input  logic [TMR_AW-1:0]  addr_i,
    input  logic               user_i,
    input  logic [FIELD_W-1:0] cnt_i,
    input  logic [LIMF_W-1:0]  lim_i,
    input  logic               reached_i,
    input  logic               run_i,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int unsigned LIM_TOP = FRAC_W + LIMF_W;
    localparam int unsigned WIDE_W  = 2 * DATA_W;

    logic [WIDE_W-1:0] wide;
    logic [DATA_W-1:0] lim_word, cnt_word, run_word;

    always_comb begin
        wide                          = '0;
        wide[FRAC_W+FIELD_W-1:FRAC_W] = cnt_i;
        lim_word                      = '0;
        lim_word[LIM_TOP-1:FRAC_W]    = lim_i;
        cnt_word                      = '0;
        cnt_word[LIM_TOP-1:FRAC_W]    = cnt_i[LIMF_W-1:0];
        cnt_word[DATA_W-1]            = reached_i;
        run_word                      = '0;
        run_word[0]                   = run_i;
    end

    always_comb begin
        case (addr_i)
            WD_LIM:  rdata_o = user_i ? wide[WIDE_W-1:DATA_W] : lim_word;
            WD_CNT:  rdata_o = user_i ? wide[DATA_W-1:0]      : cnt_word;
            WD_RUN:  rdata_o = run_word;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/proc_ctimer.sv
module proc_ctimer
    import ctimer_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FRAC_W  = 9,
    parameter int unsigned LIMF_W  = 22,
    parameter int unsigned FIELD_W = 54
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              user_mode_i,
    input  logic              mode_chg_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [TMR_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int unsigned LIM_TOP = FRAC_W + LIMF_W;

    typedef struct packed {
        logic [LIMF_W-1:0] lim;
        logic              reached;
        logic              irq;
        logic              run;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    localparam top_st_t RST_ST = '{lim: '1, reached: 1'b0, irq: 1'b0,
                                   run: 1'b1, rdata: '0};

    top_st_t            st_d, st_q;
    tmr_ctl_t           ctl;
    logic [FIELD_W-1:0] cnt;
    logic [FIELD_W-1:0] lim_ext;
    logic               hit;
    logic               adv;
    logic               cnt_clr;
    logic [LIMF_W-1:0]  wr_field;
    logic [DATA_W-1:0]  rd_word;
    logic               wdata_unused;

    assign wdata_unused = ^{wdata_i[DATA_W-1:LIM_TOP], wdata_i[FRAC_W-1:1]};

    ctimer_decode u_dec (
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .user_i  (user_mode_i),
        .addr_i  (addr_i),
        .ctl_o   (ctl)
    );

    always_comb begin
        lim_ext               = '0;
        lim_ext[LIMF_W-1:0]   = st_q.lim;
        adv                   = tick_i && (st_q.run || !user_mode_i);
        cnt_clr               = mode_chg_i || ctl.cnt_clr;
    end

    ctimer_count #(.FIELD_W(FIELD_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (cnt_clr),
        .adv_i     (adv),
        .wrap_en_i (!user_mode_i),
        .lim_i     (lim_ext),
        .cnt_o     (cnt),
        .hit_o     (hit)
    );

    ctimer_rdmux #(
        .DATA_W  (DATA_W),
        .FRAC_W  (FRAC_W),
        .LIMF_W  (LIMF_W),
        .FIELD_W (FIELD_W)
    ) u_rd (
        .addr_i    (addr_i),
        .user_i    (user_mode_i),
        .cnt_i     (cnt),
        .lim_i     (st_q.lim),
        .reached_i (st_q.reached),
        .run_i     (st_q.run),
        .rdata_o   (rd_word)
    );

    always_comb begin
        st_d     = st_q;
        wr_field = wdata_i[LIM_TOP-1:FRAC_W];
        if (wr_field == '0) begin
            wr_field = '1;
        end

        if (rd_en_i) begin
            st_d.rdata = rd_word;
        end

        if (mode_chg_i) begin
            st_d.lim     = '1;
            st_d.reached = 1'b0;
            st_d.irq     = 1'b0;
            st_d.run     = 1'b1;
        end else begin
            if (ctl.ld_lim) begin
                st_d.lim = wr_field;
            end
            if (hit) begin
                st_d.reached = 1'b1;
            end else if (ctl.rd_clr) begin
                st_d.reached = 1'b0;
            end
            if (hit) begin
                st_d.irq = 1'b1;
            end else if (ctl.irq_clr) begin
                st_d.irq = 1'b0;
            end
            if (ctl.run_wr) begin
                st_d.run = wdata_i[0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.irq;

    always_ff @(posedge clk_i) begin
        if (rst_ni) begin
            AST_LIM_NONZERO: assert (st_q.lim != '0) else $error("limit is zero"); // R2
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o)) else $error("read data moved"); // R13

    AST_USER_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> !$past(user_mode_i)) else $error("irq in free-run mode"); // R10

    AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == WD_LIM && !user_mode_i && !hit) |=> !irq_o)
        else $error("limit read kept irq"); // R4

    AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg_i |=> (!irq_o && cnt == '0)) else $error("mode change left state"); // R12

endmodule

// File: tb/proc_ctimer_tb_top.sv
module proc_ctimer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic        mode_chg = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    logic        rd_vld = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    proc_ctimer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .user_mode_i (user_mode),
        .mode_chg_i  (mode_chg),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    always @(posedge clk) rd_vld <= rd_en;

    always @(negedge clk) begin
        if (rd_vld) begin
            exp_t e;
            n_vec++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R13 unexpected read data actual=%h expected=none", rdata);
            end else begin
                e = sb_q.pop_front();
                if (rdata !== e.val) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, rdata, e.val);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        n_vec++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic mode_pulse(input logic m);
        user_mode = m; mode_chg = 1'b1;
        @(negedge clk);
        mode_chg = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_irq(1'b0, "R1 reset irq");
        rd(3'd1, 32'h0000_0000, "R1 reset count");
        rd(3'd0, 32'h7FFF_FE00, "R1 reset limit");
        rd(3'd3, 32'h0000_0001, "R1 reset running");

        // R2 masking, R6 reach and wrap
        wr(3'd0, 32'h0000_09FF);
        ticks(3);
        rd(3'd1, 32'h0000_0600, "R5 count before limit");
        chk_irq(1'b0, "R6 irq before limit");
        ticks(1);
        chk_irq(1'b1, "R6 irq at limit");
        rd(3'd1, 32'h8000_0000, "R6 reached and wrapped");
        chk_irq(1'b1, "R5 count read keeps irq");
        rd(3'd0, 32'h0000_0800, "R4 limit readback masked");
        chk_irq(1'b0, "R4 limit read clears irq");
        rd(3'd1, 32'h0000_0000, "R4 reached cleared");

        // R2 zero substitution
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, 32'h7FFF_FE00, "R2 zero substituted");

        // R3 limit change keeps count
        wr(3'd0, 32'h0000_1000);
        ticks(5);
        wr(3'd2, 32'h0000_0C00);
        rd(3'd1, 32'h0000_0A00, "R3 count kept");
        ticks(1);
        chk_irq(1'b1, "R3 new limit reached");
        rd(3'd1, 32'h8000_0000, "R3 wrap at new limit");
        rd(3'd0, 32'h0000_0C00, "R3 limit readback");
        wr(3'd2, 32'h0000_01FF);
        rd(3'd0, 32'h7FFF_FE00, "R3 zero substituted");

        // R2 write word 0 lowers irq, keeps reached
        wr(3'd0, 32'h0000_0600);
        ticks(3);
        chk_irq(1'b1, "R6 limit 3 reached");
        wr(3'd0, 32'h0000_0600);
        chk_irq(1'b0, "R2 write lowers irq");
        rd(3'd1, 32'h8000_0000, "R2 reached kept count zero");

        // R8 / R9 limit-mode ignored writes
        ticks(2);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'h8000_0400, "R8 word1 write ignored in limit mode");
        wr(3'd3, 32'h0000_0000);
        rd(3'd3, 32'h0000_0001, "R9 run write ignored in limit mode");
        ticks(1);
        chk_irq(1'b1, "R9 counter kept running in limit mode");
        rd(3'd0, 32'h0000_0600, "R4 clear after ignored writes");

        // R11 unused words
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd4, 32'h0, "R11 word4 zero");
        rd(3'd5, 32'h0, "R11 word5 zero");
        rd(3'd6, 32'h0, "R11 word6 zero");
        rd(3'd7, 32'h0, "R11 word7 zero");
        rd(3'd0, 32'h0000_0600, "R11 limit untouched");
        rd(3'd1, 32'h0000_0000, "R11 count untouched");

        // R12 mode change into free-run
        ticks(3);
        chk_irq(1'b1, "R12 irq before mode change");
        mode_pulse(1'b1);
        chk_irq(1'b0, "R12 mode change lowers irq");
        rd(3'd0, 32'h0, "R7 upper word zero");
        rd(3'd1, 32'h0, "R12 count zero");
        rd(3'd3, 32'h1, "R12 running");

        // R7 free-run counting, R9 start/stop
        ticks(10);
        rd(3'd1, 32'h0000_1400, "R7 lower word");
        rd(3'd0, 32'h0, "R7 upper word");
        chk_irq(1'b0, "R10 no irq in free-run");
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h0, "R9 stopped status");
        ticks(5);
        rd(3'd1, 32'h0000_1400, "R9 stopped holds");
        wr(3'd3, 32'h1);
        rd(3'd3, 32'h1, "R9 started status");
        ticks(2);
        rd(3'd1, 32'h0000_1800, "R9 resumed counting");
        wr(3'd0, 32'h0);
        rd(3'd1, 32'h0, "R8 word0 write zeroes count");
        ticks(3);
        rd(3'd1, 32'h0000_0600, "R8 count after clear");
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, 32'h0, "R8 word1 write zeroes count");
        ticks(20);
        chk_irq(1'b0, "R10 no irq after long free-run");
        wr(3'd3, 32'h0);

        // R12 mode change back to limit mode while stopped
        mode_pulse(1'b0);
        rd(3'd3, 32'h1, "R12 running after change");
        rd(3'd0, 32'h7FFF_FE00, "R12 limit restored");
        rd(3'd1, 32'h0, "R12 count zero after change");
        chk_irq(1'b0, "R12 irq low after change");
        ticks(4);
        rd(3'd1, 32'h0000_0800, "R6 counting with default limit");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R13 missing read data actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule